// File: doc/BRIEF.md
# Transparent Serial Frame Link

This block moves byte frames over a point-to-point bit-serial wire pair without flags, bit stuffing or a clear-to-send handshake. The transmit half accepts bytes from a valid/ready stream; each byte carries an end-of-frame marker, and the first byte of a frame carries a flag that asks for a check sequence. It serialises the bytes onto a data line and holds a frame strobe high for exactly as long as the frame's bits are on the wire. The strobe is the only frame delimiter: the far side wires it to its active-low carrier-detect input.

The receive half samples its data line while carrier-detect is low and packs the bits into bytes. When the carrier goes away it reports the end of the frame at once, together with two status bits. One says that a partly filled byte was thrown away. The other says that the check sequence did not verify. The two halves share no state and run on separate bit-rate enables, so each direction of a link can use its own clocking. The bit order inside a byte is picked by an input.

Top module: `tsl_link`

## Requirements
- R1: After reset and between frames, `rts` is 0 and `txd` is 1.
- R2: No handshake gates a frame start. In an idle transmitter, every cycle with `tx_bit_en` high drives `tx_ready` high. If `tx_valid` is high in such a cycle, the byte is taken, and `rts` rises at that clock edge together with the byte's first bit on `txd`.
- R3: When `msb_first` is 1, bit 7 of a byte goes onto the wire first. When it is 0, bit 0 goes first. The receiver packs bits back into bytes by the same rule.
- R4: `rts` stays high with no gap through all data bits and any check bits. It falls at the bit tick that follows the last bit, so a frame of N bytes holds `rts` high for 8·N ticks, or 8·N+16 ticks when the check is appended.
- R5: The check is appended only if `tx_crc_en` was high with the frame's first byte. It is CRC-16 with polynomial 0x1021 and preset 0xFFFF, computed over the data bits in wire order. Its one's complement is sent highest bit first.
- R6: `txd` and `rts` change only at clock edges where `tx_bit_en` is high. The receiver samples `rxd` and `cd_n` only at edges where `rx_bit_en` is high.
- R7: If a frame needs another byte and `tx_valid` is low at that byte boundary, the transmitter pulses `tx_underrun` for one cycle and returns the line to idle (R1) at that same tick.
- R8: Bits are accepted only at ticks where `cd_n` is 0. Each eighth accepted bit pulses `rx_valid` for one cycle with the assembled byte on `rx_data`. While `cd_n` stays 1, `rxd` has no effect.
- R9: The first receive tick that finds `cd_n` at 1 after accepted bits pulses `rx_end` for one cycle. Frame end waits for nothing else.
- R10: At `rx_end`, `rx_trunc` is 1 exactly when bits of an incomplete byte were dropped. Those bits never appear on `rx_data`.
- R11: At `rx_end`, `rx_crc_err` is 1 exactly when `rx_crc_chk` is 1, the frame is not truncated, and the CRC register run over every received bit (data and check) does not equal 0x1D0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit_en | input | 1 | Transmit bit-rate enable |
| rx_bit_en | input | 1 | Receive bit-rate enable |
| msb_first | input | 1 | 1: bit 7 first on the wire, 0: bit 0 first |
| tx_valid | input | 1 | Byte offered to the transmitter |
| tx_data | input | BYTE_W | Offered byte |
| tx_last | input | 1 | Offered byte closes the frame |
| tx_crc_en | input | 1 | Append check sequence (sampled with first byte) |
| tx_ready | output | 1 | Transmitter takes the byte this cycle |
| txd | output | 1 | Serial data out |
| rts | output | 1 | Frame strobe out, high during a frame |
| tx_underrun | output | 1 | One-cycle pulse: frame cut short for lack of data |
| rxd | input | 1 | Serial data in |
| cd_n | input | 1 | Active-low carrier detect (peer's strobe) |
| rx_crc_chk | input | 1 | Verify the check sequence at frame end |
| rx_valid | output | 1 | One-cycle pulse: received byte on rx_data |
| rx_data | output | BYTE_W | Received byte |
| rx_end | output | 1 | One-cycle pulse: frame ended |
| rx_trunc | output | 1 | With rx_end: partial byte discarded |
| rx_crc_err | output | 1 | With rx_end: check sequence failed |

## Verification
The transmitter and receiver are tested in loopback, with frames of one to five bytes in both bit orders, with and without the check sequence. This shows whether bit order, frame length and check placement are correct, because the bench rebuilds the expected wire bit stream from the requirements and compares the received bytes, check bytes included, against it. Starving the input at a byte boundary separates an underrun from a normal end. Cutting carrier-detect partway through a byte separates a truncated end from a clean one and shows whether the receiver stops before the sender does. Flipping one wire bit shows that the check really fails, and toggling the data line with no carrier present shows that it is ignored.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

    localparam int          CRC_W       = 16;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    // register value left after a frame plus its complemented check
    localparam logic [15:0] CRC_RESIDUE = 16'h1D0F;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_CHK  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic txd;
        logic rts;
    } line_t;

    typedef struct packed {
        logic done;
        logic trunc;
        logic crc_bad;
    } rx_end_t;

    // one serial step of the check register, bit taken in wire order
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/tsl_tx.sv
module tsl_tx
    import tsl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              msb_first,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_crc_en,
    output logic              in_ready,
    output logic              txd,
    output logic              rts,
    output logic              underrun
);

    localparam int MAXB = (BYTE_W > CRC_W) ? BYTE_W : CRC_W;
    localparam int CW   = $clog2(MAXB + 1);
    localparam logic [CW-1:0] BYTE_END = CW'(BYTE_W);
    localparam logic [CW-1:0] CHK_END  = CW'(CRC_W);

    tx_state_e         state;
    logic [BYTE_W-1:0] sh;
    logic              dir_msb;
    logic [CW-1:0]     cnt;
    logic              last_q;
    logic              chk_q;
    logic [15:0]       crc;
    logic [15:0]       chk_sh;
    line_t             line;
    logic              und_q;

    logic              at_boundary;
    logic              take;
    logic              ld_bit;
    logic [BYTE_W-1:0] ld_sh;
    logic              cur_bit;
    logic [BYTE_W-1:0] nxt_sh;

    assign at_boundary = (state == TX_DATA) && (cnt == BYTE_END);
    assign take        = bit_en && ((state == TX_IDLE) || (at_boundary && !last_q));
    assign in_ready    = take;

    assign ld_bit  = msb_first ? in_data[BYTE_W-1] : in_data[0];
    assign ld_sh   = msb_first ? {in_data[BYTE_W-2:0], 1'b0} : {1'b0, in_data[BYTE_W-1:1]};
    assign cur_bit = dir_msb ? sh[BYTE_W-1] : sh[0];
    assign nxt_sh  = dir_msb ? {sh[BYTE_W-2:0], 1'b0} : {1'b0, sh[BYTE_W-1:1]};

    assign txd      = line.txd;
    assign rts      = line.rts;
    assign underrun = und_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            sh      <= '0;
            dir_msb <= 1'b1;
            cnt     <= '0;
            last_q  <= 1'b0;
            chk_q   <= 1'b0;
            crc     <= CRC_PRESET;
            chk_sh  <= '0;
            line    <= '{txd: 1'b1, rts: 1'b0};
            und_q   <= 1'b0;
        end else begin
            und_q <= 1'b0;
            if (bit_en) begin
                unique case (state)
                    TX_IDLE: begin
                        if (in_valid) begin
                            sh      <= ld_sh;
                            dir_msb <= msb_first;
                            last_q  <= in_last;
                            chk_q   <= in_crc_en;
                            crc     <= crc_step(CRC_PRESET, ld_bit);
                            cnt     <= CW'(1);
                            line    <= '{txd: ld_bit, rts: 1'b1};
                            state   <= TX_DATA;
                        end
                    end
                    TX_DATA: begin
                        if (cnt != BYTE_END) begin
                            line.txd <= cur_bit;
                            sh       <= nxt_sh;
                            crc      <= crc_step(crc, cur_bit);
                            cnt      <= cnt + CW'(1);
                        end else if (!last_q) begin
                            if (in_valid) begin
                                sh       <= ld_sh;
                                dir_msb  <= msb_first;
                                last_q   <= in_last;
                                crc      <= crc_step(crc, ld_bit);
                                cnt      <= CW'(1);
                                line.txd <= ld_bit;
                            end else begin
                                und_q <= 1'b1;
                                line  <= '{txd: 1'b1, rts: 1'b0};
                                cnt   <= '0;
                                state <= TX_IDLE;
                            end
                        end else if (chk_q) begin
                            line.txd <= ~crc[15];
                            chk_sh   <= {~crc[14:0], 1'b0};
                            cnt      <= CW'(1);
                            state    <= TX_CHK;
                        end else begin
                            line  <= '{txd: 1'b1, rts: 1'b0};
                            cnt   <= '0;
                            state <= TX_IDLE;
                        end
                    end
                    TX_CHK: begin
                        if (cnt != CHK_END) begin
                            line.txd <= chk_sh[15];
                            chk_sh   <= {chk_sh[14:0], 1'b0};
                            cnt      <= cnt + CW'(1);
                        end else begin
                            line  <= '{txd: 1'b1, rts: 1'b0};
                            cnt   <= '0;
                            state <= TX_IDLE;
                        end
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE) |-> (txd && !rts));                              // R1
    AST_RTS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(rts) |-> $past(in_valid && in_ready));                        // R2
    AST_RTS_END_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(rts) |-> $past(bit_en));                                      // R4
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(txd) && $stable(rts)));                        // R6
    AST_UNDERRUN_DROP: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (!rts && $past(rts)));                                 // R7

endmodule

// File: rtl/tsl_rx.sv
module tsl_rx
    import tsl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              msb_first,
    input  logic              rxd,
    input  logic              cd_n,
    input  logic              crc_chk,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              frame_end,
    output logic              truncated,
    output logic              crc_error
);

    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

    logic              in_frame;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] nxt_acc;
    logic [15:0]       crc;
    logic              val_q;
    logic [BYTE_W-1:0] dat_q;
    rx_end_t           stat;

    assign nxt_acc = msb_first ? {acc[BYTE_W-2:0], rxd} : {rxd, acc[BYTE_W-1:1]};

    assign out_valid = val_q;
    assign out_data  = dat_q;
    assign frame_end = stat.done;
    assign truncated = stat.trunc;
    assign crc_error = stat.crc_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            cnt      <= '0;
            acc      <= '0;
            crc      <= CRC_PRESET;
            val_q    <= 1'b0;
            dat_q    <= '0;
            stat     <= '0;
        end else begin
            val_q <= 1'b0;
            stat  <= '0;
            if (bit_en) begin
                if (!cd_n) begin
                    in_frame <= 1'b1;
                    acc      <= nxt_acc;
                    crc      <= crc_step(crc, rxd);
                    if (cnt == LAST_BIT) begin
                        val_q <= 1'b1;
                        dat_q <= nxt_acc;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end else if (in_frame) begin
                    in_frame <= 1'b0;
                    stat     <= '{done:    1'b1,
                                  trunc:   (cnt != '0),
                                  crc_bad: crc_chk && (cnt == '0) && (crc != CRC_RESIDUE)};
                    cnt      <= '0;
                    crc      <= CRC_PRESET;
                end
            end
        end
    end

    AST_BYTE_NEEDS_CD: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(!cd_n && bit_en));                              // R8
    AST_END_ON_CD_LOSS: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> $past(cd_n && bit_en));                               // R9
    AST_TRUNC_AT_END: assert property (@(posedge clk) disable iff (rst)
        truncated |-> frame_end);                                           // R10
    AST_CRC_CLEAN_ONLY: assert property (@(posedge clk) disable iff (rst)
        crc_error |-> (frame_end && !truncated));                           // R11

endmodule

// File: rtl/tsl_link.sv
module tsl_link
    import tsl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_bit_en,
    input  logic              rx_bit_en,
    input  logic              msb_first,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              tx_crc_en,
    output logic              tx_ready,
    output logic              txd,
    output logic              rts,
    output logic              tx_underrun,
    input  logic              rxd,
    input  logic              cd_n,
    input  logic              rx_crc_chk,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_end,
    output logic              rx_trunc,
    output logic              rx_crc_err
);

    tsl_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (tx_bit_en),
        .msb_first (msb_first),
        .in_valid  (tx_valid),
        .in_data   (tx_data),
        .in_last   (tx_last),
        .in_crc_en (tx_crc_en),
        .in_ready  (tx_ready),
        .txd       (txd),
        .rts       (rts),
        .underrun  (tx_underrun)
    );

    tsl_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (rx_bit_en),
        .msb_first (msb_first),
        .rxd       (rxd),
        .cd_n      (cd_n),
        .crc_chk   (rx_crc_chk),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .frame_end (rx_end),
        .truncated (rx_trunc),
        .crc_error (rx_crc_err)
    );

endmodule

// File: tb/tb_tsl_link.sv
`timescale 1ns/1ps
module tb_tsl_link;

    typedef struct packed {
        logic [3:0] len;
        logic       crc;
        logic       msb;
        logic [7:0] base;
        logic [7:0] nbits;   // expected rts-high ticks
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 1'b0, 1'b1, 8'hA5, 8'd8},
        '{4'd1, 1'b1, 1'b0, 8'h3C, 8'd24},
        '{4'd3, 1'b1, 1'b1, 8'h00, 8'd40},
        '{4'd4, 1'b0, 1'b0, 8'hF0, 8'd32},
        '{4'd5, 1'b1, 1'b0, 8'h81, 8'd56},
        '{4'd2, 1'b0, 1'b1, 8'hFF, 8'd16}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       bit_en;
    logic [1:0] div;
    logic       msb_first = 1'b1;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_last = 1'b0;
    logic       tx_crc_en = 1'b0;
    logic       tx_ready, txd, rts, tx_underrun;
    logic       rx_crc_chk = 1'b0;
    logic       rx_valid, rx_end, rx_trunc, rx_crc_err;
    logic [7:0] rx_data;
    logic       flip = 1'b0;
    logic       cut = 1'b0;
    logic       rxd, cd_n;

    assign rxd  = txd ^ flip;
    assign cd_n = ~rts | cut;

    always @(posedge clk) begin
        if (rst) begin div <= '0; bit_en <= 1'b0; end
        else begin
            div    <= (div == 2'd2) ? 2'd0 : div + 2'd1;
            bit_en <= (div == 2'd1);
        end
    end

    tsl_link #(.BYTE_W(8)) dut (
        .clk(clk), .rst(rst), .tx_bit_en(bit_en), .rx_bit_en(bit_en),
        .msb_first(msb_first), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_crc_en(tx_crc_en), .tx_ready(tx_ready),
        .txd(txd), .rts(rts), .tx_underrun(tx_underrun), .rxd(rxd),
        .cd_n(cd_n), .rx_crc_chk(rx_crc_chk), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .rx_trunc(rx_trunc),
        .rx_crc_err(rx_crc_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // monitor state
    int         nbits, nrx, nend, nund, viol;
    logic       bits [256];
    logic [7:0] rxb [64];
    logic       end_trunc, end_crc, end_rts;
    logic       last_txd = 1'b1;
    logic       last_en = 1'b0;

    // expected stream
    logic       exp_b [256];
    int         exp_n;

    always @(negedge clk) begin
        if (!rst) begin
            if (txd !== last_txd && !last_en) viol++;
            last_txd = txd;
            last_en  = bit_en;
            if (bit_en && rts && nbits < 256) begin bits[nbits] = txd; nbits++; end
            if (rx_valid && nrx < 64) begin rxb[nrx] = rx_data; nrx++; end
            if (rx_end) begin
                nend++; end_trunc = rx_trunc; end_crc = rx_crc_err; end_rts = rts;
            end
            if (tx_underrun) nund++;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    function automatic logic [7:0] byte_at(input logic [7:0] base, input int i);
        return base + 8'(i * 37);
    endfunction

    task automatic build_exp(input int len, input bit crc, input bit msb, input logic [7:0] base);
        logic [15:0] c;
        logic [7:0]  d;
        c = 16'hFFFF;
        exp_n = 0;
        for (int i = 0; i < len; i++) begin
            d = byte_at(base, i);
            for (int k = 0; k < 8; k++) begin
                exp_b[exp_n] = msb ? d[7-k] : d[k];
                c = ref_crc(c, exp_b[exp_n]);
                exp_n++;
            end
        end
        if (crc) begin
            for (int k = 15; k >= 0; k--) begin
                exp_b[exp_n] = ~c[k];
                exp_n++;
            end
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        nbits = 0; nrx = 0; nend = 0; nund = 0;
        end_trunc = 1'b0; end_crc = 1'b0; end_rts = 1'b0;
    endtask

    task automatic send(input int len, input bit crc, input logic [7:0] base, input bit no_last);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tx_valid  = 1'b1;
            tx_data   = byte_at(base, i);
            tx_last   = (i == len - 1) && !no_last;
            tx_crc_en = crc;
            while (!tx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        tx_valid = 1'b0;
        tx_last  = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 3000 && nend == 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic compare_stream(input bit msb, input string tag);
        int mism;
        logic [7:0] eb;
        mism = 0;
        for (int i = 0; i < exp_n && i < nbits; i++)
            if (bits[i] !== exp_b[i]) mism++;
        check(mism == 0, {tag, " R3 R5 wire bit mismatches"}, mism, 0);
        check(nrx == exp_n / 8, {tag, " R8 received byte count"}, nrx, exp_n / 8);
        mism = 0;
        for (int j = 0; j < exp_n / 8 && j < nrx; j++) begin
            eb = '0;
            for (int k = 0; k < 8; k++)
                eb = msb ? {eb[6:0], exp_b[j*8+k]} : {exp_b[j*8+k], eb[7:1]};
            if (rxb[j] !== eb) mism++;
        end
        check(mism == 0, {tag, " R3 R8 received byte mismatches"}, mism, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        nbits = 0; nrx = 0; nend = 0; nund = 0; viol = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset line state
        check(txd === 1'b1 && rts === 1'b0, "R1 line after reset (txd,rts)", {txd, rts}, 2'b10);
        check(rx_valid === 1'b0 && rx_end === 1'b0, "R8 no receive output after reset", rx_valid, 0);
        while (!bit_en) @(negedge clk);
        check(tx_ready === 1'b1, "R2 ready on idle tick", tx_ready, 1);

        // table of frames
        for (int v = 0; v < NV; v++) begin
            msb_first  = VEC[v].msb;
            rx_crc_chk = VEC[v].crc;
            build_exp(int'(VEC[v].len), VEC[v].crc, VEC[v].msb, VEC[v].base);
            clear_mon();
            send(int'(VEC[v].len), VEC[v].crc, VEC[v].base, 1'b0);
            wait_end();
            check(nbits == int'(VEC[v].nbits), "R4 R5 rts-high ticks", nbits, int'(VEC[v].nbits));
            compare_stream(VEC[v].msb, "table");
            check(nend == 1 && end_trunc == 1'b0, "R9 single clean end", nend, 1);
            check(end_crc == 1'b0, "R11 good frame passes check", end_crc, 0);
        end
        check(txd === 1'b1 && rts === 1'b0, "R1 idle line between frames", {txd, rts}, 2'b10);

        // underrun: two bytes, none marked last
        msb_first = 1'b1; rx_crc_chk = 1'b0;
        build_exp(2, 1'b0, 1'b1, 8'h5A);
        clear_mon();
        send(2, 1'b0, 8'h5A, 1'b1);
        wait_end();
        check(nund == 1, "R7 underrun pulse count", nund, 1);
        check(nbits == 16, "R7 frame cut at byte boundary", nbits, 16);
        compare_stream(1'b1, "underrun");
        check(nend == 1 && end_trunc == 1'b0, "R9 end after underrun", nend, 1);

        // carrier lost mid-byte
        msb_first = 1'b0;
        clear_mon();
        fork
            send(3, 1'b0, 8'h11, 1'b0);
            begin
                wait (nbits == 12);
                @(negedge clk);
                cut = 1'b1;
            end
        join
        wait_end();
        check(nrx == 1, "R10 only whole bytes delivered", nrx, 1);
        check(nend == 1 && end_trunc == 1'b1, "R10 truncated status", end_trunc, 1);
        check(end_rts == 1'b1, "R9 end while peer still sending", end_rts, 1);
        check(end_crc == 1'b0, "R11 no check error on truncation", end_crc, 0);
        while (rts) @(negedge clk);
        cut = 1'b0;
        check(nbits == 24, "R4 sender unaffected by carrier cut", nbits, 24);

        // corrupted bit with check enabled
        msb_first = 1'b1; rx_crc_chk = 1'b1;
        clear_mon();
        fork
            send(3, 1'b1, 8'h42, 1'b0);
            begin
                wait (nbits == 5);
                flip = 1'b1;
                wait (nbits == 6);
                flip = 1'b0;
            end
        join
        wait_end();
        check(nend == 1 && end_crc == 1'b1, "R11 corrupted frame flagged", end_crc, 1);

        // line activity without carrier
        clear_mon();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            flip = ~flip;
        end
        flip = 1'b0;
        repeat (6) @(negedge clk);
        check(nrx == 0 && nend == 0, "R8 rxd ignored without carrier", nrx + nend, 0);

        check(viol == 0, "R6 txd changes off tick", viol, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule